// File: doc/BRIEF.md
# Memory Concurrency Performance Monitor

This block attaches beside one cache level and gathers, cycle by cycle, the raw counts from which software derives concurrency-aware memory metrics. These are the concurrent average access time, accesses per memory-active cycle, miss rate, average outstanding misses, and the share of miss time that actually stalls. Each cycle the cache presents how many hits are in service, how many misses are outstanding, a strobe for each new access and each newly detected miss, and a strobe with an identifier for each retiring miss.

The monitor classifies every cycle as hit, miss, pure-miss (misses outstanding with no hit in service) or memory-active. It also follows up to 2^ID_W misses by identifier, so that it can tell which of them ever sat through a pure-miss cycle. Ten saturating counters accumulate these events and concurrency sums. A snapshot pulse freezes all of them into shadow registers at once, which gives software a coherent set to divide. A clear pulse restarts the live counts.

Top module: `memconc_monitor`

## Requirements
- R1: Each cycle with `accessIssue` high adds one to the access count, and each cycle with `missDetect` high adds one to the miss count, so miss rate is misses over accesses.
- R2: A cycle with `missCount` nonzero adds one to the miss-cycle count. A cycle with `missCount` nonzero and `hitCount` zero also adds one to the pure-miss-cycle count, so the pure-miss-cycle count never exceeds the miss-cycle count.
- R3: A cycle with `hitCount` or `missCount` nonzero adds exactly one to the active-cycle count, however many accesses overlap in it.
- R4: A cycle with `hitCount` nonzero adds one to the hit-cycle count and adds `hitCount` to the hit concurrency sum.
- R5: Each pure-miss cycle adds `missCount` to the pure-miss concurrency sum. No other cycle changes this sum.
- R6: Each miss cycle adds `missCount` to the outstanding-miss sum, which together with the miss-cycle count gives the average miss parallelism.
- R7: A miss is tracked from its `missDetect` cycle through its `missRetire` cycle, both inclusive. If any of those cycles is a pure-miss cycle, the retire adds one to the pure-miss count. A retire for an identifier that is not being tracked is ignored. A detect and a retire of the same identifier in one cycle form a one-cycle miss.
- R8: A `snapshotReq` cycle copies every live counter and the overflow flag, as they stood before that clock edge, to the `snap*` outputs, which change one edge later. The `snap*` outputs hold their values in all other cycles.
- R9: A `clearReq` cycle with `snapshotReq` low zeroes the live counters, the overflow flag and all per-miss pure flags, and that cycle's own increments are discarded. Misses still in flight stay tracked. When both pulses are high, the snapshot is taken and the clear is ignored.
- R10: A counter that would pass its all-ones value stays at all-ones, and a sticky overflow flag is set. The flag stays set until a clear.
- R11: After reset, all live counters, all snapshot outputs and the overflow flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hitCount | input | HIT_W | Hits in service this cycle |
| missCount | input | MISS_W | Misses outstanding this cycle |
| accessIssue | input | 1 | A new access is issued this cycle |
| missDetect | input | 1 | A new miss is detected this cycle |
| missDetectId | input | ID_W | Identifier of the detected miss |
| missRetire | input | 1 | A miss retires this cycle |
| missRetireId | input | ID_W | Identifier of the retiring miss |
| snapshotReq | input | 1 | Copy live counters to the snapshot outputs |
| clearReq | input | 1 | Zero live counters and pure flags |
| snapAccesses | output | CNT_W | Frozen access count |
| snapMisses | output | CNT_W | Frozen miss count |
| snapPureMisses | output | CNT_W | Frozen pure-miss count |
| snapActiveCycles | output | CNT_W | Frozen memory-active cycle count |
| snapHitCycles | output | CNT_W | Frozen hit cycle count |
| snapMissCycles | output | CNT_W | Frozen miss cycle count |
| snapPureMissCycles | output | CNT_W | Frozen pure-miss cycle count |
| snapHitConcSum | output | CNT_W | Frozen sum of hits in service over hit cycles |
| snapPureConcSum | output | CNT_W | Frozen sum of outstanding misses over pure-miss cycles |
| snapOutstandingSum | output | CNT_W | Frozen sum of outstanding misses over miss cycles |
| snapOverflow | output | 1 | Frozen sticky saturation flag |

## Verification
The hardest case to reach is the pure-miss count. The counter depends on when a tracked miss first overlaps a hit-free cycle: at its detect cycle, in the middle of its life, at its retire cycle, or never. A clear that falls while the miss is in flight also changes the result. The bench steps one identifier at a time through each of these timelines, with hand-picked hit and miss counts per cycle, and adds a stray retire and a same-cycle detect and retire. A second instance with narrow counters reaches saturation within a few dozen cycles, so the sticky flag can be checked and then cleared.

// File: rtl/memconc_pkg.sv
package memconc_pkg;

  // Counter slots inside the live and shadow arrays
  localparam int IDX_ACCESS   = 0;
  localparam int IDX_MISS     = 1;
  localparam int IDX_PUREMISS = 2;
  localparam int IDX_ACTIVE   = 3;
  localparam int IDX_HITCYC   = 4;
  localparam int IDX_MISSCYC  = 5;
  localparam int IDX_PURECYC  = 6;
  localparam int IDX_HITSUM   = 7;
  localparam int IDX_PURESUM  = 8;
  localparam int IDX_OUTSUM   = 9;
  localparam int NUM_CNT      = 10;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic hitCycle;
    logic missCycle;
    logic pureCycle;
    logic activeCycle;
    logic accessStb;
    logic missStb;
    logic pureRetire;
    logic snap;
    logic clear;
  } ctrlStrobes_t;

endpackage

// File: rtl/memconc_satcnt.sv
module memconc_satcnt #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic [W-1:0] inc,
  output logic [W-1:0] value,
  output logic         satHit
);

  logic [W:0] sum;

  assign sum    = {1'b0, value} + {1'b0, inc};
  assign satHit = sum[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       value <= '0;
    else if (clr)    value <= '0;
    else if (sum[W]) value <= '1;
    else             value <= sum[W-1:0];
  end

endmodule

// File: rtl/memconc_ctrl.sv
module memconc_ctrl
  import memconc_pkg::*;
#(
  parameter int HIT_W  = 4,
  parameter int MISS_W = 5,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HIT_W-1:0]  hitCount,
  input  logic [MISS_W-1:0] missCount,
  input  logic              accessIssue,
  input  logic              missDetect,
  input  logic [ID_W-1:0]   missDetectId,
  input  logic              missRetire,
  input  logic [ID_W-1:0]   missRetireId,
  input  logic              snapshotReq,
  input  logic              clearReq,
  output ctrlStrobes_t      strobes
);

  localparam int DEPTH = 1 << ID_W;

  logic [DEPTH-1:0] entryValid, entryPure;
  logic [DEPTH-1:0] validNow, validNext, pureNext;
  logic             hitCyc, missCyc, pureCyc, doClear;
  logic             retireHit, retireFlag;

  // Cycle classification
  always_comb begin
    hitCyc  = (hitCount != '0);
    missCyc = (missCount != '0);
    pureCyc = missCyc && !hitCyc;
    doClear = clearReq && !snapshotReq;
  end

  // Miss table: validity and sticky pure flags
  always_comb begin
    validNow = entryValid;
    if (missDetect) validNow[missDetectId] = 1'b1;

    retireHit = missRetire && validNow[missRetireId];
    if (missDetect && (missDetectId == missRetireId))
      retireFlag = pureCyc;
    else
      retireFlag = entryPure[missRetireId] || pureCyc;

    pureNext = entryPure | (validNow & {DEPTH{pureCyc}});
    if (missDetect) pureNext[missDetectId] = pureCyc;

    validNext = validNow;
    if (retireHit) begin
      validNext[missRetireId] = 1'b0;
      pureNext[missRetireId]  = 1'b0;
    end
    if (doClear) pureNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid <= '0;
      entryPure  <= '0;
    end else begin
      entryValid <= validNext;
      entryPure  <= pureNext;
    end
  end

  always_comb begin
    strobes.hitCycle    = hitCyc;
    strobes.missCycle   = missCyc;
    strobes.pureCycle   = pureCyc;
    strobes.activeCycle = hitCyc || missCyc;
    strobes.accessStb   = accessIssue;
    strobes.missStb     = missDetect;
    strobes.pureRetire  = retireHit && retireFlag;
    strobes.snap        = snapshotReq;
    strobes.clear       = doClear;
  end

endmodule

// File: rtl/memconc_datapath.sv
module memconc_datapath
  import memconc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HIT_W  = 4,
  parameter int MISS_W = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strobes,
  input  logic [HIT_W-1:0]                hitCount,
  input  logic [MISS_W-1:0]               missCount,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   liveCounts,
  output logic                            liveOverflow,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   snapCounts,
  output logic                            snapOverflow
);

  logic [NUM_CNT-1:0][CNT_W-1:0] incVec;
  logic [NUM_CNT-1:0]            satHits;

  always_comb begin
    incVec               = '0;
    incVec[IDX_ACCESS]   = CNT_W'(strobes.accessStb);
    incVec[IDX_MISS]     = CNT_W'(strobes.missStb);
    incVec[IDX_PUREMISS] = CNT_W'(strobes.pureRetire);
    incVec[IDX_ACTIVE]   = CNT_W'(strobes.activeCycle);
    incVec[IDX_HITCYC]   = CNT_W'(strobes.hitCycle);
    incVec[IDX_MISSCYC]  = CNT_W'(strobes.missCycle);
    incVec[IDX_PURECYC]  = CNT_W'(strobes.pureCycle);
    incVec[IDX_HITSUM]   = strobes.hitCycle  ? CNT_W'(hitCount)  : '0;
    incVec[IDX_PURESUM]  = strobes.pureCycle ? CNT_W'(missCount) : '0;
    incVec[IDX_OUTSUM]   = strobes.missCycle ? CNT_W'(missCount) : '0;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gen_cnt
    memconc_satcnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strobes.clear),
      .inc    (incVec[g]),
      .value  (liveCounts[g]),
      .satHit (satHits[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              liveOverflow <= 1'b0;
    else if (strobes.clear) liveOverflow <= 1'b0;
    else if (|satHits)      liveOverflow <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapCounts   <= '0;
      snapOverflow <= 1'b0;
    end else if (strobes.snap) begin
      snapCounts   <= liveCounts;
      snapOverflow <= liveOverflow;
    end
  end

endmodule

// File: rtl/memconc_monitor.sv
module memconc_monitor
  import memconc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HIT_W  = 4,
  parameter int MISS_W = 5,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HIT_W-1:0]  hitCount,
  input  logic [MISS_W-1:0] missCount,
  input  logic              accessIssue,
  input  logic              missDetect,
  input  logic [ID_W-1:0]   missDetectId,
  input  logic              missRetire,
  input  logic [ID_W-1:0]   missRetireId,
  input  logic              snapshotReq,
  input  logic              clearReq,
  output logic [CNT_W-1:0]  snapAccesses,
  output logic [CNT_W-1:0]  snapMisses,
  output logic [CNT_W-1:0]  snapPureMisses,
  output logic [CNT_W-1:0]  snapActiveCycles,
  output logic [CNT_W-1:0]  snapHitCycles,
  output logic [CNT_W-1:0]  snapMissCycles,
  output logic [CNT_W-1:0]  snapPureMissCycles,
  output logic [CNT_W-1:0]  snapHitConcSum,
  output logic [CNT_W-1:0]  snapPureConcSum,
  output logic [CNT_W-1:0]  snapOutstandingSum,
  output logic              snapOverflow
);

  ctrlStrobes_t                  strobes;
  logic [NUM_CNT-1:0][CNT_W-1:0] liveCounts, snapCounts;
  logic                          liveOverflow;

  memconc_ctrl #(.HIT_W(HIT_W), .MISS_W(MISS_W), .ID_W(ID_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hitCount     (hitCount),
    .missCount    (missCount),
    .accessIssue  (accessIssue),
    .missDetect   (missDetect),
    .missDetectId (missDetectId),
    .missRetire   (missRetire),
    .missRetireId (missRetireId),
    .snapshotReq  (snapshotReq),
    .clearReq     (clearReq),
    .strobes      (strobes)
  );

  memconc_datapath #(.CNT_W(CNT_W), .HIT_W(HIT_W), .MISS_W(MISS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .hitCount     (hitCount),
    .missCount    (missCount),
    .liveCounts   (liveCounts),
    .liveOverflow (liveOverflow),
    .snapCounts   (snapCounts),
    .snapOverflow (snapOverflow)
  );

  assign snapAccesses       = snapCounts[IDX_ACCESS];
  assign snapMisses         = snapCounts[IDX_MISS];
  assign snapPureMisses     = snapCounts[IDX_PUREMISS];
  assign snapActiveCycles   = snapCounts[IDX_ACTIVE];
  assign snapHitCycles      = snapCounts[IDX_HITCYC];
  assign snapMissCycles     = snapCounts[IDX_MISSCYC];
  assign snapPureMissCycles = snapCounts[IDX_PURECYC];
  assign snapHitConcSum     = snapCounts[IDX_HITSUM];
  assign snapPureConcSum    = snapCounts[IDX_PURESUM];
  assign snapOutstandingSum = snapCounts[IDX_OUTSUM];

endmodule

// File: rtl/memconc_checker.sv
module memconc_checker
  import memconc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int HIT_W  = 4,
  parameter int MISS_W = 5
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [HIT_W-1:0]              hitCount,
  input logic [MISS_W-1:0]             missCount,
  input logic                          snapshotReq,
  input logic                          clearReq,
  input logic [NUM_CNT-1:0][CNT_W-1:0] liveCounts,
  input logic                          liveOverflow,
  input logic [CNT_W-1:0]              snapAccesses
);

  // R2
  pure_le_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveCounts[IDX_PURECYC] <= liveCounts[IDX_MISSCYC]);

  // R3
  active_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(clearReq && !snapshotReq) && (hitCount != '0 || missCount != '0)
      && liveCounts[IDX_ACTIVE] != '1)
    |=> liveCounts[IDX_ACTIVE] == $past(liveCounts[IDX_ACTIVE]) + CNT_W'(1));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !snapshotReq |=> $stable(snapAccesses));

  // R8
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    snapshotReq |=> snapAccesses == $past(liveCounts[IDX_ACCESS]));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !snapshotReq) |=> (liveCounts == '0) && !liveOverflow);

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveOverflow && !(clearReq && !snapshotReq)) |=> liveOverflow);

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (liveCounts[IDX_ACTIVE] == '1 && !(clearReq && !snapshotReq))
    |=> liveCounts[IDX_ACTIVE] == '1);

endmodule

bind memconc_monitor memconc_checker #(
  .CNT_W(CNT_W), .HIT_W(HIT_W), .MISS_W(MISS_W)
) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .hitCount     (hitCount),
  .missCount    (missCount),
  .snapshotReq  (snapshotReq),
  .clearReq     (clearReq),
  .liveCounts   (liveCounts),
  .liveOverflow (liveOverflow),
  .snapAccesses (snapAccesses)
);

// File: tb/memconc_monitor_test.sv
`timescale 1ns/1ps
module memconc_monitor_test;

  localparam int CNT_W  = 64;
  localparam int NCNT_W = 8;
  localparam int HIT_W  = 4;
  localparam int MISS_W = 5;
  localparam int ID_W   = 4;

  // Stimulus vectors: hits, misses, accessIssue, repeat count
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{2,  0, 1, 5},
    '{0,  3, 0, 4},
    '{1,  2, 1, 6},
    '{0,  0, 0, 7},
    '{3, 16, 1, 3},
    '{0, 16, 0, 2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [HIT_W-1:0]  hitCount = '0;
  logic [MISS_W-1:0] missCount = '0;
  logic accessIssue = 1'b0, missDetect = 1'b0, missRetire = 1'b0;
  logic [ID_W-1:0] missDetectId = '0, missRetireId = '0;
  logic snapshotReq = 1'b0, clearReq = 1'b0;

  logic [CNT_W-1:0] sAcc, sMiss, sPMiss, sAct, sHitC, sMissC, sPureC, sHitS, sPureS, sOutS;
  logic sOvf;
  logic [NCNT_W-1:0] nAcc, nMiss, nPMiss, nAct, nHitC, nMissC, nPureC, nHitS, nPureS, nOutS;
  logic nOvf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  memconc_monitor #(.CNT_W(CNT_W), .HIT_W(HIT_W), .MISS_W(MISS_W), .ID_W(ID_W)) uut (
    .clk(clk), .rstN(rstN), .hitCount(hitCount), .missCount(missCount),
    .accessIssue(accessIssue), .missDetect(missDetect), .missDetectId(missDetectId),
    .missRetire(missRetire), .missRetireId(missRetireId),
    .snapshotReq(snapshotReq), .clearReq(clearReq),
    .snapAccesses(sAcc), .snapMisses(sMiss), .snapPureMisses(sPMiss),
    .snapActiveCycles(sAct), .snapHitCycles(sHitC), .snapMissCycles(sMissC),
    .snapPureMissCycles(sPureC), .snapHitConcSum(sHitS), .snapPureConcSum(sPureS),
    .snapOutstandingSum(sOutS), .snapOverflow(sOvf)
  );

  memconc_monitor #(.CNT_W(NCNT_W), .HIT_W(HIT_W), .MISS_W(MISS_W), .ID_W(ID_W)) uutNarrow (
    .clk(clk), .rstN(rstN), .hitCount(hitCount), .missCount(missCount),
    .accessIssue(accessIssue), .missDetect(missDetect), .missDetectId(missDetectId),
    .missRetire(missRetire), .missRetireId(missRetireId),
    .snapshotReq(snapshotReq), .clearReq(clearReq),
    .snapAccesses(nAcc), .snapMisses(nMiss), .snapPureMisses(nPMiss),
    .snapActiveCycles(nAct), .snapHitCycles(nHitC), .snapMissCycles(nMissC),
    .snapPureMissCycles(nPureC), .snapHitConcSum(nHitS), .snapPureConcSum(nPureS),
    .snapOutstandingSum(nOutS), .snapOverflow(nOvf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle of activity, driven after a falling edge
  task automatic drive(input int h, input int m, input bit acc,
                       input bit det, input int dId, input bit ret, input int rId);
    hitCount     = HIT_W'(h);
    missCount    = MISS_W'(m);
    accessIssue  = acc;
    missDetect   = det;
    missDetectId = ID_W'(dId);
    missRetire   = ret;
    missRetireId = ID_W'(rId);
    @(negedge clk);
    hitCount = '0; missCount = '0; accessIssue = 1'b0;
    missDetect = 1'b0; missRetire = 1'b0;
  endtask

  task automatic snap();
    snapshotReq = 1'b1;
    @(negedge clk);
    snapshotReq = 1'b0;
  endtask

  task automatic clr();
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 snapAccesses in reset", sAcc, 0);
    chk("R11 snapActive in reset", sAct, 0);
    chk("R11 snapOverflow in reset", {63'd0, sOvf}, 0);
    rstN = 1'b1;
    @(negedge clk);
    snap();
    chk("R11 live access count after reset", sAcc, 0);
    chk("R11 live pure-miss cycles after reset", sPureC, 0);

    // Table walk: constant pattern for a number of cycles
    for (int v = 0; v < NV; v++) begin
      int h, m, a, n;
      h = VEC[v][0]; m = VEC[v][1]; a = VEC[v][2]; n = VEC[v][3];
      clr();
      for (int c = 0; c < n; c++) drive(h, m, a[0], 1'b0, 0, 1'b0, 0);
      snap();
      chk("R1 accesses", sAcc, 64'(a * n));
      chk("R3 active cycles", sAct, 64'((h != 0 || m != 0) ? n : 0));
      chk("R4 hit cycles", sHitC, 64'((h != 0) ? n : 0));
      chk("R4 hit concurrency sum", sHitS, 64'(h * n));
      chk("R2 miss cycles", sMissC, 64'((m != 0) ? n : 0));
      chk("R2 pure-miss cycles", sPureC, 64'((m != 0 && h == 0) ? n : 0));
      chk("R5 pure-miss concurrency sum", sPureS, 64'((h == 0) ? m * n : 0));
      chk("R6 outstanding sum", sOutS, 64'(m * n));
    end

    // R7: pure-miss tagging across miss timelines
    clr();
    drive(1, 1, 1, 1, 3, 0, 0);   // id3 detected, hit present
    drive(1, 1, 0, 0, 0, 1, 3);   // id3 retires, never pure
    drive(0, 1, 1, 1, 5, 0, 0);   // id5 detected in a pure cycle
    drive(1, 1, 0, 0, 0, 1, 5);   // id5 retires: pure
    drive(1, 1, 1, 1, 7, 0, 0);   // id7 detected
    drive(0, 1, 0, 0, 0, 0, 0);   // pure cycle mid-life
    drive(1, 1, 0, 0, 0, 1, 7);   // id7 retires: pure
    drive(0, 0, 0, 0, 0, 1, 9);   // stray retire of untracked id9
    drive(0, 1, 1, 1, 4, 1, 4);   // id4 detect and retire together in a pure cycle
    drive(1, 1, 1, 1, 6, 0, 0);   // id6 detected
    drive(0, 1, 0, 0, 0, 1, 6);   // id6 retires in a pure cycle
    snap();
    chk("R7 pure misses", sPMiss, 4);
    chk("R1 misses", sMiss, 5);
    chk("R1 accesses in miss scenario", sAcc, 5);
    chk("R2 pure-miss cycles in miss scenario", sPureC, 4);

    // R9: clear wipes pure flags but keeps the miss tracked
    clr();
    drive(0, 1, 0, 1, 2, 0, 0);   // id2 detected in a pure cycle
    clr();
    drive(1, 1, 0, 0, 0, 1, 2);   // id2 retires after clear, no pure cycle since
    snap();
    chk("R9 pure flag cleared", sPMiss, 0);
    chk("R9 miss detected before clear dropped", sMiss, 0);
    chk("R9 active after clear", sAct, 1);
    chk("R9 miss cycles after clear", sMissC, 1);

    // R9/R8: snapshot wins over clear, then shadow holds
    clr();
    for (int c = 0; c < 3; c++) drive(1, 0, 0, 0, 0, 0, 0);
    snapshotReq = 1'b1; clearReq = 1'b1;
    @(negedge clk);
    snapshotReq = 1'b0; clearReq = 1'b0;
    chk("R9 snapshot taken with clear", sAct, 3);
    snap();
    chk("R9 clear ignored alongside snapshot", sAct, 3);
    for (int c = 0; c < 2; c++) drive(1, 0, 0, 0, 0, 0, 0);
    chk("R8 shadow holds without snapshot", sAct, 3);
    snap();
    chk("R8 new snapshot", sAct, 5);

    // R10: saturation on the narrow instance
    clr();
    for (int c = 0; c < 20; c++) drive(15, 0, 0, 0, 0, 0, 0);
    snap();
    chk("R10 narrow hit sum saturates", 64'(nHitS), 255);
    chk("R10 narrow overflow flag", {63'd0, nOvf}, 1);
    chk("R10 narrow active keeps counting", 64'(nAct), 20);
    chk("R10 wide no overflow", {63'd0, sOvf}, 0);
    clr();
    snap();
    chk("R9 overflow cleared", {63'd0, nOvf}, 0);
    chk("R9 narrow hit sum cleared", 64'(nHitS), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule